// File: doc/BRIEF.md
# TDM Frame-Sync Slot Receiver

This block receives a serial time-division-multiplexed stream. Its clock is the stream's bit clock, and a word clock marks where each frame starts. On every rising bit-clock edge it samples the word clock and the serial data line. A rising edge of the word clock starts a new frame. The block then counts bits within 16-bit slots and counts slots within the frame. As each slot completes, it presents the assembled word together with the slot number and a one-cycle strobe.

Only the rising edge of the word clock is used. The same logic therefore works when the sync pulse is one bit clock wide, one slot wide, or half the frame wide, and no mode setting is needed. A frame has a fixed length of slots × 16 bit clocks. If a word-clock rise comes earlier than that, the block raises an error pulse. It also raises one if the expected rise is missing when that length has passed. Either way, it realigns on the next rise. Until the first rise after reset, the data line is ignored.

Top module: `tdm_slot_rx`

## Requirements
- R1: After reset, word_o, slot_o, word_valid_o and frame_err_o are all zero. No word and no error appear until the first rising edge of wclk_i after reset. A wclk_i that is already high when reset ends does not count as a rising edge: it must first be sampled low.
- R2: A frame starts on the bit-clock edge where wclk_i is sampled high after having been sampled low. The bit sampled on that same edge is the most significant bit of slot 0. The falling edge of wclk_i has no effect on framing.
- R3: Each slot is 16 bits, sent most significant bit first. word_o bit 15 holds the first bit received in the slot and bit 0 the last.
- R4: word_valid_o is high for exactly one cycle. That cycle directly follows the edge that captured the 16th bit of a slot, so a complete frame produces NUM_SLOTS strobes.
- R5: slot_o, which is valid while word_valid_o is high, gives the slot's position in the frame. The first slot after the frame start is 0, and the value rises by one per slot up to NUM_SLOTS-1.
- R6: A wclk_i high time of one bit clock, of 16 bit clocks, or of half the frame gives the same words, slot numbers and strobes.
- R7: A wclk_i rise that comes before NUM_SLOTS × 16 bits of the current frame have been received gives a one-cycle frame_err_o pulse in the cycle after that edge. The incomplete slot is dropped, and the rise starts a new frame at slot 0.
- R8: If NUM_SLOTS × 16 bits have been received and the next edge shows no rise, frame_err_o pulses for one cycle after that edge. After that, no word is produced until the next rise.
- R9: word_valid_o and frame_err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Word clock (frame sync) |
| sdata_i | input | 1 | Serial data, MSB first |
| word_o | output | 16 | Last completed slot word |
| slot_o | output | $clog2(NUM_SLOTS) | Slot index of word_o |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| frame_err_o | output | 1 | One-cycle pulse on a short or long frame |

## Verification
Each output has a single register between the sampling edge and the port. A word is therefore due in the cycle right after the edge that captured its 16th bit. An error pulse is due in the cycle after the edge that had the early rise or missed the expected one. The reference model in the bench updates its expected values at each rising edge from the inputs that edge sampled. It compares them with the outputs at the following falling edge, so every comparison lands in the cycle the result is due. The per-frame counts of strobes and errors are read one falling edge after the next frame's first edge, by which time the previous frame's last strobe has been registered.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int unsigned SLOT_BITS = 16;

    typedef enum logic [1:0] {
        FE_NONE  = 2'd0,
        FE_SHORT = 2'd1,
        FE_LONG  = 2'd2
    } frame_evt_e;

    typedef struct packed {
        logic load_first;
        logic shift;
        logic word_done;
    } cap_ctrl_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic wclk_i,
    output logic rise_o
);
    logic prev_q;

    // Reset to high so a word clock already high at reset is not a rise.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= wclk_i;
    end

    assign rise_o = wclk_i & ~prev_q;
endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 16,
    parameter  int unsigned WORD_W    = SLOT_BITS,
    localparam int unsigned SLOT_W    = idx_width(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    output cap_ctrl_t         ctrl_o,
    output logic [SLOT_W-1:0] slot_o,
    output frame_evt_e        evt_o
);
    localparam int unsigned BIT_W  = idx_width(WORD_W);
    localparam int unsigned SCNT_W = idx_width(NUM_SLOTS + 1);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [SCNT_W-1:0] END_SLOT = SCNT_W'(NUM_SLOTS);

    logic              locked_q;
    logic [BIT_W-1:0]  bit_q;
    logic [SCNT_W-1:0] slot_q;
    logic              frame_end;

    assign frame_end = (slot_q == END_SLOT);

    always_comb begin
        ctrl_o = '0;
        evt_o  = FE_NONE;
        if (rise_i) begin
            ctrl_o.load_first = 1'b1;
            if (locked_q && !frame_end) evt_o = FE_SHORT;
        end else if (locked_q) begin
            if (frame_end) begin
                evt_o = FE_LONG;
            end else begin
                ctrl_o.shift = 1'b1;
                if (bit_q == LAST_BIT) ctrl_o.word_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            bit_q    <= '0;
            slot_q   <= '0;
        end else if (rise_i) begin
            locked_q <= 1'b1;
            bit_q    <= BIT_W'(1);
            slot_q   <= '0;
        end else if (locked_q) begin
            if (frame_end) begin
                locked_q <= 1'b0;
                bit_q    <= '0;
                slot_q   <= '0;
            end else if (bit_q == LAST_BIT) begin
                bit_q  <= '0;
                slot_q <= slot_q + SCNT_W'(1);
            end else begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    assign slot_o = slot_q[SLOT_W-1:0];
endmodule

// File: rtl/tdm_rx_assembler.sv
module tdm_rx_assembler
    import tdm_rx_pkg::*;
#(
    parameter int unsigned WORD_W = SLOT_BITS,
    parameter int unsigned SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cap_ctrl_t         ctrl_i,
    input  logic              sdata_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [WORD_W-1:0] word_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              valid_o
);
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] next_word;

    assign next_word = {shift_q[WORD_W-2:0], sdata_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            word_o  <= '0;
            slot_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            if (ctrl_i.load_first)  shift_q <= {{(WORD_W-1){1'b0}}, sdata_i};
            else if (ctrl_i.shift)  shift_q <= next_word;
            valid_o <= ctrl_i.word_done;
            if (ctrl_i.word_done) begin
                word_o <= next_word;
                slot_o <= slot_i;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 16,
    parameter  int unsigned WORD_W    = SLOT_BITS,
    localparam int unsigned SLOT_W    = idx_width(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wclk_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              word_valid_o,
    output logic              frame_err_o
);
    logic              rise;
    cap_ctrl_t         ctrl;
    logic [SLOT_W-1:0] cur_slot;
    frame_evt_e        evt;

    tdm_rx_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .wclk_i (wclk_i),
        .rise_o (rise)
    );

    tdm_rx_framer #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORD_W    (WORD_W)
    ) u_framer (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise),
        .ctrl_o (ctrl),
        .slot_o (cur_slot),
        .evt_o  (evt)
    );

    tdm_rx_assembler #(
        .WORD_W (WORD_W),
        .SLOT_W (SLOT_W)
    ) u_asm (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (ctrl),
        .sdata_i (sdata_i),
        .slot_i  (cur_slot),
        .word_o  (word_o),
        .slot_o  (slot_o),
        .valid_o (word_valid_o)
    );

    always_ff @(posedge clk) begin
        if (rst) frame_err_o <= 1'b0;
        else     frame_err_o <= (evt != FE_NONE);
    end
endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk (
    input logic clk,
    input logic rst,
    input logic wclk_i,
    input logic word_valid_o,
    input logic frame_err_o
);
    logic wprev_q;
    logic seen_q;
    logic rise_c;

    assign rise_c = wclk_i && !wprev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wprev_q <= 1'b1;
            seen_q  <= 1'b0;
        end else begin
            wprev_q <= wclk_i;
            seen_q  <= seen_q | rise_c;
        end
    end

    assert_quiet_before_sync_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (!word_valid_o && !frame_err_o));

    assert_no_word_after_rise_R2: assert property (@(posedge clk) disable iff (rst)
        rise_c |=> !word_valid_o);

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);

    assert_valid_err_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(word_valid_o && frame_err_o));
endmodule

bind tdm_slot_rx tdm_slot_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wclk_i       (wclk_i),
    .word_valid_o (word_valid_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/tdm_slot_rx_bench.sv
module tdm_slot_rx_bench;
    localparam int NS = 16;
    localparam int WW = 16;
    localparam int FB = NS * WW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wclk = 1'b1;
    logic sdata = 1'b0;
    logic [15:0] word;
    logic [3:0]  slot;
    logic        valid;
    logic        err;

    always #10 clk = ~clk;

    tdm_slot_rx u_tdm_slot_rx (
        .clk          (clk),
        .rst          (rst),
        .wclk_i       (wclk),
        .sdata_i      (sdata),
        .word_o       (word),
        .slot_o       (slot),
        .word_valid_o (valid),
        .frame_err_o  (err)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    int nvalid = 0;
    int nerr   = 0;
    int mark_v = 0;
    int mark_e = 0;
    logic [15:0] lf = 16'hACE1;

    // Behavioural reference model
    bit m_prev, m_in;
    int m_pos;
    bit m_q[$];
    logic [15:0] e_word;
    int e_slot;
    bit e_valid, e_err;

    always @(posedge clk) begin : model
        bit r;
        if (rst) begin
            m_prev = 1; m_in = 0; m_pos = 0; m_q.delete();
            e_valid = 0; e_err = 0; e_word = '0; e_slot = 0;
        end else begin
            r = wclk && !m_prev;
            m_prev = wclk;
            e_valid = 0;
            e_err = 0;
            if (r) begin
                e_err = m_in && (m_pos != FB);
                m_in = 1; m_pos = 1; m_q.delete(); m_q.push_back(sdata);
            end else if (m_in) begin
                if (m_pos == FB) begin
                    e_err = 1; m_in = 0; m_q.delete();
                end else begin
                    m_q.push_back(sdata);
                    m_pos++;
                    if (m_q.size() == WW) begin
                        e_word = '0;
                        foreach (m_q[i]) e_word = {e_word[14:0], m_q[i]};
                        e_slot = (m_pos - 1) / WW;
                        e_valid = 1;
                        m_q.delete();
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (valid) nvalid++;
            if (err) nerr++;
            chk(valid == e_valid, "R4 word_valid_o", valid, e_valid);
            chk(err == e_err, "R8 frame_err_o (short R7 / long)", err, e_err);
            if (valid && e_valid) begin
                chk(word == e_word, "R3 word_o", word, e_word);
                chk(int'(slot) == e_slot, "R5 slot_o", slot, e_slot);
            end
        end
    end

    task automatic drive(input bit w);
        @(negedge clk);
        wclk = w;
        sdata = lf[0];
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    // Sends one frame segment; at its second bit checks strobes/errors since the last mark.
    task automatic frame(input int len, input int high, input int exp_v, input int exp_e,
                         input string tag);
        for (int i = 0; i < len; i++) begin
            drive(i < high);
            if (i == 1) begin
                #1;
                if (exp_v >= 0) begin
                    chk(nvalid - mark_v == exp_v, {tag, " strobes"}, nvalid - mark_v, exp_v);
                    chk(nerr - mark_e == exp_e, {tag, " errors"}, nerr - mark_e, exp_e);
                end
                mark_v = nvalid;
                mark_e = nerr;
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(valid == 0 && err == 0 && word == 0 && slot == 0, "R1 reset state",
            {valid, err, word}, 0);
        @(negedge clk);
        rst = 1'b0;
        // R1: word clock held high after reset is not a frame start
        for (int i = 0; i < 20; i++) drive(1'b1);
        repeat (3) drive(1'b0);
        #1;
        chk(nvalid == 0 && nerr == 0, "R1 quiet before first rise", nvalid + nerr, 0);
        // R2, R6: one-bit sync pulse
        frame(FB, 1, -1, 0, "R2 first frame");
        frame(FB, 1, NS, 0, "R4 one-bit pulse");
        frame(FB, 16, NS, 0, "R6 one-bit pulse");
        frame(FB, 16, NS, 0, "R6 one-slot pulse");
        frame(FB, FB / 2, NS, 0, "R6 one-slot pulse");
        frame(FB, FB / 2, NS, 0, "R6 half-frame pulse");
        // R7: short frame of 100 bits
        frame(100, 1, NS, 0, "R6 half-frame pulse");
        frame(FB, 16, 6, 1, "R7 short frame");
        // R8: long frame, 40 extra bits with no rise
        frame(FB + 40, 1, NS, 0, "R5 frame after resync");
        frame(FB, FB / 2, NS, 1, "R8 long frame");
        frame(FB, 1, NS, 0, "R6 recovery");
        frame(4, 1, NS, 0, "R4 last full frame");
        repeat (5) drive(1'b0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired (all requirements) actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule